// File: doc/BRIEF.md
# Multi-Bank Clock Divider with Coincidence Sync

This block sits behind a phase-locked loop and runs on its fast oscillator-rate clock. It derives three banks of four outputs each (A, B, C) and one feedback output. Each bank and the feedback path has its own divider with its own static ratio select. All outputs are registered logic levels in the fast clock domain. Every divided output has a 50% duty cycle: it is high for the first half of each period and low for the second half.

A single active-high input puts the block into reset and disables its outputs. While it is high, every output, including the sync flag, is driven low and all dividers are reloaded. On release, all dividers start together, so every bank rises on the same fast-clock edge.

An active-low sync flag warns that banks A and C are about to rise together. It falls one full period of the faster of those two banks ahead of the shared rising edge. It rises again on that shared edge. This works even when the two bank rates are not integer multiples of each other.

Individual outputs can be stopped. A stopped output parks low, and a stop only starts or ends during the output's low phase. Output 0 of bank C and the feedback output ignore stop requests.

Top module: `mbank_divsync`

## Requirements
- R1: Each bank divides the fast clock by a ratio chosen by its 4-bit select. Codes 0..8 give 2, 4, 6, 8, 10, 12, 16, 20, 24, and any code above 8 gives 24. A bank output is high for the first N/2 fast cycles of each N-cycle period.
- R2: The feedback output divides the fast clock by a ratio chosen by its 4-bit select. Codes 0..9 give 4, 6, 8, 10, 12, 16, 20, 24, 32, 40, and any code above 9 gives 40. Its duty cycle is 50%.
- R3: On the first fast-clock edge after reset is released, every unstopped output and the feedback output rise together. Every later period counts from that edge, independently per bank.
- R4: Let P be the smaller of the A and C ratios. `sync_n` is driven low starting P fast cycles before each edge on which banks A and C both rise. This holds for ratios that are non-integer multiples of each other.
- R5: `sync_n` goes high on each shared A/C rising edge and stays high until the next low window. When the A and C ratios are equal, this leaves it high for exactly one fast cycle per period.
- R6: `stop_req` bits [3:0] stop `qa[3:0]`, bits [7:4] stop `qb[3:0]`, and bits [10:8] stop `qc[3:1]`. A stopped output is held low. A request is sampled only during the output's low phase, so no high pulse is ever shortened. A release restarts the output at the start of the next high phase.
- R7: `qc[0]` and `qfb` never respond to `stop_req`.
- R8: While `rst_oe` is high, all outputs (`qa`, `qb`, `qc`, `qfb`, `sync_n`) are low from the next edge onward. Any pending stops are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator-rate clock |
| rst_oe | input | 1 | Synchronous reset and output disable, active high |
| sel_a | input | 4 | Bank A ratio code |
| sel_b | input | 4 | Bank B ratio code |
| sel_c | input | 4 | Bank C ratio code |
| sel_fb | input | 4 | Feedback ratio code |
| stop_req | input | 11 | Per-output stop requests (map in R6) |
| qa | output | 4 | Bank A outputs |
| qb | output | 4 | Bank B outputs |
| qc | output | 4 | Bank C outputs, bit 0 not stoppable |
| qfb | output | 1 | Feedback output |
| sync_n | output | 1 | Active-low A/C coincidence warning |

## Verification
A corrupted divider counter shows up within one bank period. That bank's next edge lands on the wrong fast cycle, and if bank A or C is affected, the sync window drifts as well. A wrong stop flag yields a missing or shortened high pulse at the very next high phase. A faulty predictor shows up by the first shared A/C edge after release, which is at most the least common multiple of the two ratios away. The bench therefore runs each configuration for several of those spans, including ratio pairs with no integer relation.

// File: rtl/mbank_divsync.sv
module mbank_divsync #(
  parameter int CW = 6
) (
  input  logic        clk,
  input  logic        rst_oe,
  input  logic [3:0]  sel_a,
  input  logic [3:0]  sel_b,
  input  logic [3:0]  sel_c,
  input  logic [3:0]  sel_fb,
  input  logic [10:0] stop_req,
  output logic [3:0]  qa,
  output logic [3:0]  qb,
  output logic [3:0]  qc,
  output logic        qfb,
  output logic        sync_n
);
  localparam logic [CW-1:0] ONE = CW'(1);

  function automatic logic [CW-1:0] bank_ratio(input logic [3:0] s);
    case (s)
      4'd0: return CW'(2);
      4'd1: return CW'(4);
      4'd2: return CW'(6);
      4'd3: return CW'(8);
      4'd4: return CW'(10);
      4'd5: return CW'(12);
      4'd6: return CW'(16);
      4'd7: return CW'(20);
      default: return CW'(24);
    endcase
  endfunction

  function automatic logic [CW-1:0] fb_ratio(input logic [3:0] s);
    case (s)
      4'd0: return CW'(4);
      4'd1: return CW'(6);
      4'd2: return CW'(8);
      4'd3: return CW'(10);
      4'd4: return CW'(12);
      4'd5: return CW'(16);
      4'd6: return CW'(20);
      4'd7: return CW'(24);
      4'd8: return CW'(32);
      default: return CW'(40);
    endcase
  endfunction

  logic [CW-1:0] n  [4];
  logic [CW-1:0] dc [4];
  logic [3:0]    ph;
  logic [10:0]   stopped;
  logic          rise_a, rise_c, fast_a, arm, eq_d;

  assign n[0] = bank_ratio(sel_a);
  assign n[1] = bank_ratio(sel_b);
  assign n[2] = bank_ratio(sel_c);
  assign n[3] = fb_ratio(sel_fb);

  always_ff @(posedge clk)
    for (int i = 0; i < 4; i++)
      if (rst_oe || dc[i] == '0) dc[i] <= n[i] - ONE;
      else                      dc[i] <= dc[i] - ONE;

  always_comb
    for (int i = 0; i < 4; i++) ph[i] = dc[i] >= (n[i] >> 1);

  wire [10:0] bank_ph = {{3{ph[2]}}, {4{ph[1]}}, {4{ph[0]}}};

  always_ff @(posedge clk)
    for (int i = 0; i < 11; i++)
      if (rst_oe)          stopped[i] <= 1'b0;
      else if (!bank_ph[i]) stopped[i] <= stop_req[i];

  always_ff @(posedge clk)
    if (rst_oe) begin
      qa <= '0; qb <= '0; qc <= '0; qfb <= 1'b0;
    end else begin
      qa  <= {4{ph[0]}} & ~stopped[3:0];
      qb  <= {4{ph[1]}} & ~stopped[7:4];
      qc  <= {{3{ph[2]}} & ~stopped[10:8], ph[2]};
      qfb <= ph[3];
    end

  assign rise_a = dc[0] == n[0] - ONE;
  assign rise_c = dc[2] == n[2] - ONE;
  assign fast_a = n[0] <= n[2];
  assign arm    = fast_a ? (rise_a && dc[2] == n[0] - ONE)
                         : (rise_c && dc[0] == n[2] - ONE);

  always_ff @(posedge clk)
    if (rst_oe) begin
      sync_n <= 1'b0;
      eq_d   <= 1'b0;
    end else begin
      eq_d <= rise_a && rise_c && (n[0] == n[2]);
      if (rise_a && rise_c)  sync_n <= 1'b1;
      else if (arm || eq_d)  sync_n <= 1'b0;
    end

  // R8
  reset_off_chk: assert property (@(posedge clk)
    rst_oe |=> (qa == '0 && qb == '0 && qc == '0 && !qfb && !sync_n));

  // R3
  first_edge_chk: assert property (@(posedge clk)
    $fell(rst_oe) |=> (&qa && &qb && &qc && qfb && sync_n));

  // R5
  sync_high_chk: assert property (@(posedge clk) disable iff (rst_oe)
    (rise_a && rise_c) |=> sync_n);

  generate
    for (genvar g = 1; g < 4; g++) begin : g_stop_chk
      // R6
      stop_fall_chk: assert property (@(posedge clk) disable iff (rst_oe)
        $fell(qc[g]) |-> $fell(qc[0]));
      // R6
      stop_rise_chk: assert property (@(posedge clk) disable iff (rst_oe)
        $rose(qc[g]) |-> $rose(qc[0]));
    end
  endgenerate
endmodule

// File: tb/tb_mbank_divsync.sv
module tb_mbank_divsync;
  logic clk = 1'b0;
  logic rst_oe = 1'b1;
  logic [3:0] sel_a = '0, sel_b = '0, sel_c = '0, sel_fb = '0;
  logic [10:0] stop_req = '0;
  logic [3:0] qa, qb, qc;
  logic qfb, sync_n;

  always #10 clk = ~clk;

  mbank_divsync dut (.clk(clk), .rst_oe(rst_oe), .sel_a(sel_a), .sel_b(sel_b),
    .sel_c(sel_c), .sel_fb(sel_fb), .stop_req(stop_req), .qa(qa), .qb(qb),
    .qc(qc), .qfb(qfb), .sync_n(sync_n));

  typedef struct {
    logic [11:0] q;
    logic        fb;
    logic        sy;
    string       tag;
  } item_t;

  item_t exq[$];
  int checks = 0, errors = 0;
  int t, na, nb, nc, nf;
  logic [10:0] st;

  function automatic int bank_n(input int c);
    case (c)
      0: return 2;  1: return 4;  2: return 6;  3: return 8;  4: return 10;
      5: return 12; 6: return 16; 7: return 20; default: return 24;
    endcase
  endfunction

  function automatic int fb_n(input int c);
    case (c)
      0: return 4;  1: return 6;  2: return 8;  3: return 10; 4: return 12;
      5: return 16; 6: return 20; 7: return 24; 8: return 32; default: return 40;
    endcase
  endfunction

  function automatic int gcd(input int a, input int b);
    int x = a, y = b, r;
    while (y != 0) begin r = x % y; x = y; y = r; end
    return x;
  endfunction

  task automatic push_reset_item();
    item_t it;
    it.q = '0; it.fb = 1'b0; it.sy = 1'b0; it.tag = "R8";
    exq.push_back(it);
  endtask

  task automatic do_reset(input int ca, input int cb, input int cc, input int cf, input int cyc);
    @(negedge clk);
    rst_oe = 1'b1;
    sel_a = 4'(ca); sel_b = 4'(cb); sel_c = 4'(cc); sel_fb = 4'(cf);
    for (int k = 0; k < cyc; k++) begin
      @(posedge clk);
      push_reset_item();
    end
    @(negedge clk);
    rst_oe = 1'b0;
    na = bank_n(ca); nb = bank_n(cb); nc = bank_n(cc); nf = fb_n(cf);
    t = 0; st = '0;
  endtask

  task automatic step(input string tg);
    item_t it;
    logic pa, pb, pc;
    logic [10:0] bp;
    int l, p, r;
    @(posedge clk);
    pa = (t % na) < na / 2;
    pb = (t % nb) < nb / 2;
    pc = (t % nc) < nc / 2;
    bp = {{3{pc}}, {4{pb}}, {4{pa}}};
    it.q[3:0]  = {4{pa}} & ~st[3:0];
    it.q[7:4]  = {4{pb}} & ~st[7:4];
    it.q[11:8] = {{3{pc}} & ~st[10:8], pc};
    for (int i = 0; i < 11; i++) if (!bp[i]) st[i] = stop_req[i];
    it.fb = (t % nf) < nf / 2;
    l = na / gcd(na, nc) * nc;
    p = (na < nc) ? na : nc;
    r = t % l;
    it.sy = (r == 0) ? 1'b1 : !((l - r) <= p);
    it.tag = tg;
    exq.push_back(it);
    t++;
  endtask

  task automatic run(input int cyc, input string tg);
    for (int k = 0; k < cyc; k++) step(tg);
  endtask

  task automatic set_stop(input logic [10:0] v);
    @(negedge clk);
    stop_req = v;
  endtask

  always @(negedge clk) begin
    while (exq.size() > 0) begin
      item_t it;
      it = exq.pop_front();
      checks++;
      if ({qc, qb, qa} !== it.q) begin
        errors++;
        $display("FAIL %s banks: got %h expected %h", it.tag, {qc, qb, qa}, it.q);
      end
      checks++;
      if (qfb !== it.fb) begin
        errors++;
        $display("FAIL %s feedback (R2): got %b expected %b", it.tag, qfb, it.fb);
      end
      checks++;
      if (sync_n !== it.sy) begin
        errors++;
        $display("FAIL %s sync (R4/R5): got %b expected %b", it.tag, sync_n, it.sy);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8 reset state, R1 R2 R3 R4 ratios 4/6, fb 4
    do_reset(1, 0, 2, 0, 4);
    run(60, "R1 R3 R4");
    // R4 non-integer pair 6/4, extreme fb 40
    do_reset(2, 8, 1, 9, 3);
    run(130, "R1 R2 R4");
    // R5 equal ratios
    do_reset(0, 3, 0, 8, 2);
    run(30, "R5 R2");
    // R4 16/24
    do_reset(6, 7, 8, 5, 2);
    run(150, "R4 R1");
    // R4 10/12
    do_reset(4, 2, 5, 3, 2);
    run(130, "R4 R2");
    // R1 R2 out-of-range codes
    do_reset(15, 12, 9, 10, 2);
    run(100, "R1 R2");
    // R6 R7 stop behaviour, request raised mid-high
    do_reset(1, 0, 2, 4, 2);
    run(1, "R6 R7");
    set_stop('1);
    run(20, "R6 R7");
    set_stop('0);
    run(2, "R6");
    set_stop(11'b101_0101_0011);
    run(25, "R6 R7");
    set_stop(11'b010_1010_1100);
    run(3, "R6");
    set_stop(11'b000_0000_0000);
    run(20, "R6");
    // R8 mid-run reset clears stops, R3 restart
    set_stop('1);
    run(9, "R6 R7");
    do_reset(3, 1, 2, 2, 3);
    run(1, "R3 R8");
    set_stop('0);
    run(60, "R3 R1");
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule